// File: doc/BRIEF.md
# Load-Use Interlock and Taken-Branch Squash Controller

This block steers the pipeline registers and the program counter of a five-stage in-order pipeline. It has two jobs. The first is to hold back an instruction in decode that reads the destination register of a load still in execute. It freezes the program counter and the decode register for one cycle and sends an empty slot into execute, so the loaded value can be forwarded to the stalled instruction one cycle later. The second is to redirect fetch to the target of a taken branch or jump and to kill the younger instructions that were fetched on the wrong path.

The parameter `RESOLVE_IN_EX` sets the stage in which the `br_taken` decision arrives. When it is 1, the decision comes from execute and two younger instructions are killed: the one in decode is replaced by a bubble, and the one being fetched is flushed from the decode register. When it is 0, the decision comes from decode and only the instruction being fetched is killed. The controller keeps one liveness bit for the decode register and one for the execute register. A slot that it has flushed or bubbled therefore never raises a stall or a redirect, even if the datapath leaves that slot's stale fields in place.

Top module: `hazard_ctl`

## Requirements
- R1: When the execute slot is live, holds a load (`ex_mem_read`=1) with a nonzero `ex_dst`, and the live decode slot names `ex_dst` in `dec_src_a` or `dec_src_b`, the block drives `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1 for that cycle.
- R2: A load whose destination is register 0 never causes a stall.
- R3: A slot that was bubbled or flushed by the block in the previous cycle raises neither a stall nor a redirect, whatever stale values sit on its inputs.
- R4: On a taken branch, `pc_sel`=1 (1 means redirect), `pc_we`=1 and `next_pc` equals `br_target`.
- R5: With `RESOLVE_IN_EX`=1, a taken branch asserts both `ifid_flush` and `idex_bubble`, which squashes two younger instructions.
- R6: With `RESOLVE_IN_EX`=0, a taken branch asserts `ifid_flush` with `idex_bubble`=0, which squashes one younger instruction.
- R7: With no taken branch, `pc_sel`=0 and `next_pc` equals `seq_pc`. A not-taken branch adds no cycles.
- R8: When a redirect and a load-use stall coincide, the redirect wins: `pc_we`=1, `ifid_flush`=1, and decode is not held.
- R9: After reset, both pipeline slots are empty. No stall is raised, and `pc_we` and `ifid_we` are 1 even if the load-use inputs match.
- R10: Instructions retire in program order along the taken path. Each load-use pair costs exactly one cycle, and each taken branch costs two cycles with `RESOLVE_IN_EX`=1 and one cycle with `RESOLVE_IN_EX`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_src_a | input | REG_W | First source register of the decode-stage instruction |
| dec_src_b | input | REG_W | Second source register of the decode-stage instruction |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| br_taken | input | 1 | Taken branch or jump in the resolving stage |
| br_target | input | PC_W | Redirect address of that branch |
| seq_pc | input | PC_W | Sequential next fetch address |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Decode register load enable |
| ifid_flush | output | 1 | Turn the decode register into an empty slot |
| idex_bubble | output | 1 | Load an empty slot into the execute register |
| pc_sel | output | 1 | Next-PC select, 1 = branch target, 0 = sequential |
| next_pc | output | PC_W | Selected next fetch address |

## Verification
The hardest case to reach from the ports is a dead slot that still carries fields which would stall or redirect if the slot were live. It occurs only in the cycle right after a flush or bubble, and only when the wrong-path instruction happens to match. The bench drives a small pipeline model, one per resolve mode, that keeps the stale fields of killed slots on the inputs. It runs directed programs that pair a load with a taken branch, and many seeded random programs dense in loads, branches and a four-register namespace. Retire order and retire cycle are checked against a walk of each program.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic {
    PC_SEQ      = 1'b0,
    PC_REDIRECT = 1'b1
  } pc_src_e;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic ifid_flush;
    logic idex_bubble;
  } pipe_ctl_t;

  typedef struct packed {
    logic ifid;
    logic idex;
  } slot_live_t;

endpackage

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                     idex_live,
  input  logic                     ifid_live,
  input  logic                     mem_read,
  input  logic [REG_W-1:0]         dst,
  input  logic [NUM_SRC*REG_W-1:0] srcs,
  output logic                     hazard
);
  logic [NUM_SRC-1:0] src_hit;
  logic               dst_real;

  // one comparator per decode source operand
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign src_hit[g] = (srcs[g*REG_W +: REG_W] == dst);
  end

  assign dst_real = |dst;
  assign hazard   = idex_live & ifid_live & mem_read & dst_real & (|src_hit);
endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect
  import hzd_pkg::*;
#(
  parameter bit RESOLVE_IN_EX = 1'b1
) (
  input  logic      br_taken,
  input  logic      idex_live,
  input  logic      ifid_live,
  input  logic      hazard,
  output logic      redirect,
  output pipe_ctl_t ctl
);
  logic bubble;

  if (RESOLVE_IN_EX) begin : g_ex
    // branch sits in execute; the instruction in decode is also wrong-path
    assign redirect = br_taken & idex_live;
    assign bubble   = redirect | hazard;
  end else begin : g_id
    // branch sits in decode and moves on; a stall is overridden
    assign redirect = br_taken & ifid_live;
    assign bubble   = hazard & ~redirect;
  end

  always_comb begin
    ctl             = '0;
    ctl.pc_we       = redirect | ~hazard;
    ctl.ifid_we     = redirect | ~hazard;
    ctl.ifid_flush  = redirect;
    ctl.idex_bubble = bubble;
  end
endmodule

// File: rtl/hzd_liveness.sv
module hzd_liveness
  import hzd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ifid_we,
  input  logic       ifid_flush,
  input  logic       idex_bubble,
  output slot_live_t live
);
  slot_live_t live_q;
  slot_live_t live_d;
  logic       ifid_en;

  assign ifid_en = ifid_we | ifid_flush;

  always_comb begin
    live_d      = live_q;
    if (ifid_en) begin
      live_d.ifid = ~ifid_flush;
    end
    live_d.idex = live_q.ifid & ~idex_bubble;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else begin
      live_q <= live_d;
    end
  end

  assign live = live_q;
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hzd_pkg::*;
#(
  parameter int REG_W         = 5,
  parameter int PC_W          = 32,
  parameter bit RESOLVE_IN_EX = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             ex_mem_read,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  seq_pc,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             ifid_flush,
  output logic             idex_bubble,
  output logic             pc_sel,
  output logic [PC_W-1:0]  next_pc
);
  localparam int NUM_SRC   = 2;
  localparam int SRC_BUS_W = NUM_SRC * REG_W;

  slot_live_t           live;
  pipe_ctl_t            ctl;
  logic                 hazard;
  logic                 redirect;
  logic [SRC_BUS_W-1:0] src_bus;
  pc_src_e              pc_src;

  assign src_bus = {dec_src_b, dec_src_a};

  hzd_loaduse #(
    .REG_W  (REG_W),
    .NUM_SRC(NUM_SRC)
  ) u_loaduse (
    .idex_live(live.idex),
    .ifid_live(live.ifid),
    .mem_read (ex_mem_read),
    .dst      (ex_dst),
    .srcs     (src_bus),
    .hazard   (hazard)
  );

  hzd_redirect #(
    .RESOLVE_IN_EX(RESOLVE_IN_EX)
  ) u_redirect (
    .br_taken (br_taken),
    .idex_live(live.idex),
    .ifid_live(live.ifid),
    .hazard   (hazard),
    .redirect (redirect),
    .ctl      (ctl)
  );

  hzd_liveness u_liveness (
    .clk        (clk),
    .rst_n      (rst_n),
    .ifid_we    (ctl.ifid_we),
    .ifid_flush (ctl.ifid_flush),
    .idex_bubble(ctl.idex_bubble),
    .live       (live)
  );

  assign pc_src      = redirect ? PC_REDIRECT : PC_SEQ;
  assign pc_sel      = (pc_src == PC_REDIRECT);
  assign next_pc     = (pc_src == PC_REDIRECT) ? br_target : seq_pc;
  assign pc_we       = ctl.pc_we;
  assign ifid_we     = ctl.ifid_we;
  assign ifid_flush  = ctl.ifid_flush;
  assign idex_bubble = ctl.idex_bubble;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_W         = 5,
  parameter int PC_W          = 32,
  parameter bit RESOLVE_IN_EX = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] ex_dst,
  input logic [PC_W-1:0]  br_target,
  input logic [PC_W-1:0]  seq_pc,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             ifid_flush,
  input logic             idex_bubble,
  input logic             pc_sel,
  input logic [PC_W-1:0]  next_pc
);
  // a frozen PC means a load-use hold: decode held, execute bubbled
  assert_stall_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |-> (!ifid_we && idex_bubble && !ifid_flush));

  assert_zero_dst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> pc_we);

  assert_bubble_dead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> pc_we);

  assert_flush_dead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |=> !ifid_flush);

  assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |-> (pc_we && ifid_flush && next_pc == br_target));

  if (RESOLVE_IN_EX) begin : g_ex
    assert_two_squash_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_flush |-> idex_bubble);
  end else begin : g_id
    assert_one_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_flush |-> !idex_bubble);
  end

  assert_sequential_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_sel |-> (next_pc == seq_pc && !ifid_flush));

  assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (pc_we && ifid_we));
endmodule

bind hazard_ctl hazard_ctl_chk #(
  .REG_W        (REG_W),
  .PC_W         (PC_W),
  .RESOLVE_IN_EX(RESOLVE_IN_EX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ex_dst     (ex_dst),
  .br_target  (br_target),
  .seq_pc     (seq_pc),
  .pc_we      (pc_we),
  .ifid_we    (ifid_we),
  .ifid_flush (ifid_flush),
  .idex_bubble(idex_bubble),
  .pc_sel     (pc_sel),
  .next_pc    (next_pc)
);

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb;
  localparam int REG_W = 5;
  localparam int PC_W  = 32;
  localparam int MAXP  = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  logic [REG_W-1:0] sa[2], sb[2], dst[2];
  logic             mr[2], bt[2];
  logic [PC_W-1:0]  tgt[2], spc[2];
  logic             pcwe[2], ifwe[2], iffl[2], idb[2], psel[2];
  logic [PC_W-1:0]  npc[2];

  hazard_ctl #(.REG_W(REG_W), .PC_W(PC_W), .RESOLVE_IN_EX(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_src_a(sa[0]), .dec_src_b(sb[0]),
    .ex_mem_read(mr[0]), .ex_dst(dst[0]), .br_taken(bt[0]), .br_target(tgt[0]),
    .seq_pc(spc[0]), .pc_we(pcwe[0]), .ifid_we(ifwe[0]), .ifid_flush(iffl[0]),
    .idex_bubble(idb[0]), .pc_sel(psel[0]), .next_pc(npc[0]));

  hazard_ctl #(.REG_W(REG_W), .PC_W(PC_W), .RESOLVE_IN_EX(1'b0)) u_dut_id (
    .clk(clk), .rst_n(rst_n), .dec_src_a(sa[1]), .dec_src_b(sb[1]),
    .ex_mem_read(mr[1]), .ex_dst(dst[1]), .br_taken(bt[1]), .br_target(tgt[1]),
    .seq_pc(spc[1]), .pc_we(pcwe[1]), .ifid_we(ifwe[1]), .ifid_flush(iffl[1]),
    .idex_bubble(idb[1]), .pc_sel(psel[1]), .next_pc(npc[1]));

  // program image
  bit p_ld[MAXP], p_br[MAXP], p_tk[MAXP];
  int p_d[MAXP], p_a[MAXP], p_b[MAXP], p_t[MAXP];
  int plen;

  // pipeline model per mode: 0 = resolve in execute, 1 = resolve in decode
  int fpc[2], fi_idx[2], ex_idx[2];
  bit fi_live[2], ex_live[2];
  int exp_seq[2][MAXP], exp_t[2][MAXP], exp_n[2], rcnt[2];
  bit e_pcwe[2], e_fl[2], e_b[2];
  int e_npc[2];

  int checks = 0;
  int errors = 0;

  function automatic bit ld_at(int i); return (i < plen) ? p_ld[i] : 1'b0; endfunction
  function automatic bit br_at(int i); return (i < plen) ? (p_br[i] && p_tk[i]) : 1'b0; endfunction
  function automatic int d_at(int i);  return (i < plen) ? p_d[i] : 0; endfunction
  function automatic int a_at(int i);  return (i < plen) ? p_a[i] : 0; endfunction
  function automatic int b_at(int i);  return (i < plen) ? p_b[i] : 0; endfunction
  function automatic int t_at(int i);  return (i < plen) ? p_t[i] : 0; endfunction

  task automatic chk(bit ok, string req, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic set_inst(int i, bit ld, bit br, bit tk, int d, int a, int b, int t);
    p_ld[i] = ld; p_br[i] = br; p_tk[i] = tk;
    p_d[i] = d; p_a[i] = a; p_b[i] = b; p_t[i] = t;
  endtask

  // walk the program along the taken path; retire cycle grows per R10 costs
  task automatic build_expect();
    for (int m = 0; m < 2; m++) begin
      int i = 0;
      int k = 0;
      int t = 3;
      while (i < plen && k < MAXP) begin
        int nxt;
        exp_seq[m][k] = i;
        exp_t[m][k]   = t;
        nxt = br_at(i) ? p_t[i] : i + 1;
        t += 1;
        if (br_at(i)) t += (m == 0) ? 2 : 1;
        if (p_ld[i] && p_d[i] != 0 && nxt < plen &&
            (a_at(nxt) == p_d[i] || b_at(nxt) == p_d[i]) &&
            !(m == 1 && br_at(nxt)))
          t += 1;
        i = nxt;
        k++;
      end
      exp_n[m] = k;
    end
  endtask

  task automatic cycle_step(int u);
    for (int m = 0; m < 2; m++) begin
      int r;
      r = (m == 0) ? ex_idx[m] : fi_idx[m];
      sa[m]  = REG_W'(a_at(fi_idx[m]));
      sb[m]  = REG_W'(b_at(fi_idx[m]));
      mr[m]  = ld_at(ex_idx[m]);
      dst[m] = REG_W'(d_at(ex_idx[m]));
      bt[m]  = br_at(r);
      tgt[m] = PC_W'(t_at(r) * 4);
      spc[m] = PC_W'((fpc[m] + 1) * 4);
    end
    #1;
    for (int m = 0; m < 2; m++) begin
      bit rv, hz, raw;
      int d;
      string req;
      d   = d_at(ex_idx[m]);
      rv  = (m == 0) ? (ex_live[m] && br_at(ex_idx[m])) : (fi_live[m] && br_at(fi_idx[m]));
      raw = ld_at(ex_idx[m]) && (a_at(fi_idx[m]) == d || b_at(fi_idx[m]) == d);
      hz  = raw && d != 0 && ex_live[m] && fi_live[m];
      e_pcwe[m] = rv || !hz;
      e_fl[m]   = rv;
      e_b[m]    = (m == 0) ? (rv || hz) : (hz && !rv);
      e_npc[m]  = rv ? t_at((m == 0) ? ex_idx[m] : fi_idx[m]) * 4 : (fpc[m] + 1) * 4;
      if (u == 0)            req = "R9";
      else if (rv && hz)     req = "R8";
      else if (rv)           req = (m == 0) ? "R5" : "R6";
      else if (hz)           req = "R1";
      else if (raw && d == 0) req = "R2";
      else if (raw)          req = "R3";
      else                   req = "R7";
      chk({pcwe[m], ifwe[m], iffl[m], idb[m], psel[m]} ==
          {e_pcwe[m], e_pcwe[m], e_fl[m], e_b[m], rv}, req,
          $sformatf("mode %0d cycle %0d ctl act=%b exp=%b", m, u,
            {pcwe[m], ifwe[m], iffl[m], idb[m], psel[m]},
            {e_pcwe[m], e_pcwe[m], e_fl[m], e_b[m], rv}));
      chk(npc[m] == PC_W'(e_npc[m]), rv ? "R4" : "R7",
          $sformatf("mode %0d cycle %0d next_pc act=%0h exp=%0h", m, u, npc[m], e_npc[m]));
    end
    @(posedge clk);
    #1;
    for (int m = 0; m < 2; m++) begin
      if (ex_live[m] && ex_idx[m] < plen) begin
        if (rcnt[m] < exp_n[m]) begin
          chk(ex_idx[m] == exp_seq[m][rcnt[m]] && (u + 1) == exp_t[m][rcnt[m]], "R10",
              $sformatf("mode %0d retire #%0d act idx=%0d t=%0d exp idx=%0d t=%0d", m, rcnt[m],
                ex_idx[m], u + 1, exp_seq[m][rcnt[m]], exp_t[m][rcnt[m]]));
        end else begin
          chk(1'b0, "R10", $sformatf("mode %0d extra retire act idx=%0d exp none", m, ex_idx[m]));
        end
        rcnt[m]++;
      end
      ex_live[m] = e_b[m] ? 1'b0 : fi_live[m];
      ex_idx[m]  = fi_idx[m];
      if (e_fl[m]) begin
        fi_live[m] = 1'b0; fi_idx[m] = fpc[m];
      end else if (e_pcwe[m]) begin
        fi_live[m] = 1'b1; fi_idx[m] = fpc[m];
      end
      if (e_pcwe[m]) fpc[m] = e_npc[m] / 4;
    end
  endtask

  task automatic run_prog();
    int u = 0;
    build_expect();
    rst_n = 1'b0;
    for (int m = 0; m < 2; m++) begin
      fpc[m] = 0; fi_idx[m] = 0; ex_idx[m] = 0;
      fi_live[m] = 1'b0; ex_live[m] = 1'b0; rcnt[m] = 0;
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    while (u < 400 && !(rcnt[0] >= exp_n[0] && rcnt[1] >= exp_n[1])) begin
      cycle_step(u);
      u++;
    end
    for (int m = 0; m < 2; m++)
      chk(rcnt[m] == exp_n[m], "R10",
          $sformatf("mode %0d retired act=%0d exp=%0d", m, rcnt[m], exp_n[m]));
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    for (int m = 0; m < 2; m++) begin
      sa[m] = '0; sb[m] = '0; dst[m] = '0; mr[m] = 1'b0; bt[m] = 1'b0;
      tgt[m] = '0; spc[m] = '0;
    end

    // directed: matching inputs at reset (R9), load-use (R1), zero dst (R2),
    // taken branch (R5/R6), load feeding a taken branch (R8), not-taken (R7)
    plen = 12;
    set_inst(0, 1, 0, 0, 2, 2, 2, 0);
    set_inst(1, 0, 0, 0, 1, 2, 1, 0);
    set_inst(2, 1, 0, 0, 0, 1, 1, 0);
    set_inst(3, 0, 0, 0, 3, 0, 0, 0);
    set_inst(4, 0, 1, 1, 0, 0, 0, 7);
    set_inst(5, 1, 0, 0, 3, 1, 1, 0);
    set_inst(6, 0, 0, 0, 2, 3, 3, 0);
    set_inst(7, 1, 0, 0, 1, 2, 2, 0);
    set_inst(8, 0, 1, 1, 0, 1, 0, 10);
    set_inst(9, 0, 0, 0, 2, 1, 1, 0);
    set_inst(10, 0, 1, 0, 0, 2, 3, 11);
    set_inst(11, 0, 0, 0, 3, 1, 2, 0);
    run_prog();

    // seeded random programs, forward branches only
    for (int n = 0; n < 60; n++) begin
      plen = 8 + int'($urandom % 17);
      for (int i = 0; i < plen; i++) begin
        int r = int'($urandom % 10);
        int t = i + 2 + int'($urandom % 3);
        if (t > plen) t = plen;
        set_inst(i, r < 3, (r == 3 || r == 4), $urandom % 2 == 0,
                 int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), t);
        if (p_br[i]) p_ld[i] = 1'b0;
      end
      run_prog();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule